// File: doc/BRIEF.md
# Carry-Bubble Long Vector Adder

This block adds two wide operands plus a carry-in and returns the wide sum and a carry-out. The result always takes two clock cycles, however many fields the operands hold. Each operand is split into `NUM_FIELDS` fields of `FIELD_W` bits, and every field pair is added on its own. Carries between fields are then settled with a single narrow mask computation instead of a ripple chain.

That computation works on three per-field masks:
- a generated-carry mask, built from the top bits of the two operand fields and of their wrapped sum;
- a bubble mask, which marks fields whose wrapped sum is all ones;
- the carry-in.

The carry mask is shifted up one field and the carry-in is placed in its bottom bit. A star-closure step then sends each incoming carry through any run of bubble fields above it, using one narrow addition of `NUM_FIELDS+1` bits: `((m & b) + b) ^ b | m`. Every field flagged by the result is incremented by one. The bit just above the top field becomes the carry-out.

The field sums and masks are registered in stage 1. Mask resolution and the increments are registered in stage 2. A new operand pair can be accepted on every cycle.

Top module: `lva_adder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `outValid`, `carryOut` and `sum` are all zero.
- R2: `outValid` goes high exactly two rising edges after the edge that samples `inValid` high. Back-to-back inputs give back-to-back results, one per accepted input.
- R3: When `outValid` is high, `{carryOut, sum}` equals `opA + opB + carryIn` for the accepted input, computed as an unsigned sum of width `NUM_FIELDS*FIELD_W+1`.
- R4: With 8 fields of 8 bits, take opA = 0x1931BA4C3D4521F1, opB = 0x221245B3E2161736 and carry-in 0. The result is sum = 0x3B4400001F5B3927 with carryOut 0.
- R5: Take opA all ones, opB zero and carryIn 1. The carry-in passes through every field: sum is zero and carryOut is 1.
- R6: A carry generated in one field increments each all-ones field above it, and it stops at the first field that is not all ones. Fields above that field keep their plain field sum.
- R7: In any cycle where `outValid` is low, `sum` and `carryOut` keep the value they had on the previous cycle.
- R8: `carryOut` is 1 when the top field generates a carry with no carry arriving from below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | The operands on this cycle are accepted |
| opA | input | NUM_FIELDS*FIELD_W | First operand; field 0 is the least significant |
| opB | input | NUM_FIELDS*FIELD_W | Second operand |
| carryIn | input | 1 | Carry into field 0 |
| outValid | output | 1 | `sum` and `carryOut` hold a new result |
| sum | output | NUM_FIELDS*FIELD_W | Wide sum modulo 2^(NUM_FIELDS*FIELD_W) |
| carryOut | output | 1 | Carry out of the top field |

## Verification
The bench feeds random 256-bit operands. These mostly show whether the per-field sums and simple single-field carries are right. Directed patterns then pick apart the separate paths:
- a full-width all-ones operand with a carry-in, which tells bubble propagation apart from generated carries;
- a carry from field 0 running into a bubble field and stopping at a non-bubble field, which shows where the propagation ends;
- a top-field carry, which exercises the carry-out bit.

The worked 8-field example fixes the mask ordering against known values. Idle gaps between back-to-back bursts show the hold behaviour and the two-cycle timing.

// File: rtl/lva_pkg.sv
package lva_pkg;
  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } lvaStrobe_t;
endpackage

// File: rtl/lva_field_stage.sv
module lva_field_stage #(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 64,
  localparam int TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic [TOT_W-1:0]      opA,
  input  logic [TOT_W-1:0]      opB,
  output logic [TOT_W-1:0]      rawSum,
  output logic [NUM_FIELDS-1:0] genMask,
  output logic [NUM_FIELDS-1:0] bubbleMask
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : gField
    localparam int LO = k * FIELD_W;
    logic [FIELD_W-1:0] fieldA, fieldB, fieldSum;
    logic topA, topB, topS;
    always_comb begin
      fieldA   = opA[LO +: FIELD_W];
      fieldB   = opB[LO +: FIELD_W];
      fieldSum = fieldA + fieldB;
      topA     = fieldA[FIELD_W-1];
      topB     = fieldB[FIELD_W-1];
      topS     = fieldSum[FIELD_W-1];
    end
    assign rawSum[LO +: FIELD_W] = fieldSum;
    assign genMask[k]    = (topA & topB) | ((topA | topB) & ~topS);
    assign bubbleMask[k] = &fieldSum;
  end
endmodule

// File: rtl/lva_carry_resolve.sv
module lva_carry_resolve #(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 64,
  localparam int TOT_W     = NUM_FIELDS * FIELD_W,
  localparam int MASK_W    = NUM_FIELDS + 1
) (
  input  logic [TOT_W-1:0]      rawSum,
  input  logic [NUM_FIELDS-1:0] genMask,
  input  logic [NUM_FIELDS-1:0] bubbleMask,
  input  logic                  carryIn,
  output logic [TOT_W-1:0]      sumOut,
  output logic                  carryOut
);
  logic [MASK_W-1:0] marker, classMask, seeded, advanced, incMask;

  always_comb begin
    marker    = {genMask, carryIn};
    classMask = {1'b0, bubbleMask};
    seeded    = marker & classMask;
    advanced  = seeded + classMask;
    incMask   = (advanced ^ classMask) | marker;
  end

  assign carryOut = incMask[NUM_FIELDS];

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : gInc
    localparam int LO = k * FIELD_W;
    assign sumOut[LO +: FIELD_W] =
      rawSum[LO +: FIELD_W] + {{(FIELD_W-1){1'b0}}, incMask[k]};
  end
endmodule

// File: rtl/lva_datapath.sv
module lva_datapath
  import lva_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 64,
  localparam int TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvaStrobe_t       strobe,
  input  logic [TOT_W-1:0] opA,
  input  logic [TOT_W-1:0] opB,
  input  logic             carryIn,
  output logic [TOT_W-1:0] sum,
  output logic             carryOut
);
  logic [TOT_W-1:0]      rawSumC, rawSumQ;
  logic [NUM_FIELDS-1:0] genC, genQ, bubC, bubQ;
  logic                  cinQ;
  logic [TOT_W-1:0]      sumC;
  logic                  coutC;

  lva_field_stage #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) uFields (
    .opA(opA), .opB(opB),
    .rawSum(rawSumC), .genMask(genC), .bubbleMask(bubC)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawSumQ <= '0;
      genQ    <= '0;
      bubQ    <= '0;
      cinQ    <= 1'b0;
    end else if (strobe.loadStage1) begin
      rawSumQ <= rawSumC;
      genQ    <= genC;
      bubQ    <= bubC;
      cinQ    <= carryIn;
    end
  end

  lva_carry_resolve #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) uResolve (
    .rawSum(rawSumQ), .genMask(genQ), .bubbleMask(bubQ), .carryIn(cinQ),
    .sumOut(sumC), .carryOut(coutC)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum      <= '0;
      carryOut <= 1'b0;
    end else if (strobe.loadStage2) begin
      sum      <= sumC;
      carryOut <= coutC;
    end
  end
endmodule

// File: rtl/lva_ctrl.sv
module lva_ctrl
  import lva_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output lvaStrobe_t strobe,
  output logic       outValid
);
  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadStage1 = inValid;
    strobe.loadStage2 = stage1Valid;
  end
endmodule

// File: rtl/lva_adder.sv
module lva_adder
  import lva_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 64,
  localparam int TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [TOT_W-1:0] opA,
  input  logic [TOT_W-1:0] opB,
  input  logic             carryIn,
  output logic             outValid,
  output logic [TOT_W-1:0] sum,
  output logic             carryOut
);
  lvaStrobe_t strobe;

  lva_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  lva_datapath #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut)
  );
endmodule

// File: rtl/lva_adder_checker.sv
module lva_adder_checker #(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 64,
  localparam int TOT_W     = NUM_FIELDS * FIELD_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [TOT_W-1:0] opA,
  input logic [TOT_W-1:0] opB,
  input logic             carryIn,
  input logic             outValid,
  input logic [TOT_W-1:0] sum,
  input logic             carryOut
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!outValid && !carryOut && sum == '0));

  assert_two_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  assert_wide_sum_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({carryOut, sum} ==
      ({1'b0, $past(opA, 2)} + {1'b0, $past(opB, 2)} +
       {{TOT_W{1'b0}}, $past(carryIn, 2)})));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(sum) && $stable(carryOut)));
endmodule

bind lva_adder lva_adder_checker #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .carryIn(carryIn), .outValid(outValid), .sum(sum), .carryOut(carryOut)
);

// File: tb/sim_lva_adder.sv
`timescale 1ns/1ps
module sim_lva_adder;
  localparam int NF = 4;
  localparam int FW = 64;
  localparam int TW = NF * FW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [TW-1:0] opA = '0, opB = '0;
  logic          carryIn = 1'b0;
  logic          outValid, carryOut;
  logic [TW-1:0] sum;

  lva_adder #(.NUM_FIELDS(NF), .FIELD_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .carryIn(carryIn), .outValid(outValid), .sum(sum), .carryOut(carryOut)
  );

  logic        smValid = 1'b0;
  logic [63:0] smA = '0, smB = '0;
  logic        smOutValid, smCout;
  logic [63:0] smSum;

  lva_adder #(.NUM_FIELDS(8), .FIELD_W(8)) uSmall (
    .clk(clk), .rstN(rstN), .inValid(smValid), .opA(smA), .opB(smB),
    .carryIn(1'b0), .outValid(smOutValid), .sum(smSum), .carryOut(smCout)
  );

  int checks = 0;
  int errors = 0;
  string curTag = "R3";

  // behavioural reference: two pipeline slots plus the held result
  logic          s1Valid = 1'b0, s2Valid = 1'b0;
  logic [TW:0]   s1Exp = '0, heldExp = '0;
  string         s1Tag = "R3", heldTag = "R3";

  always @(posedge clk) begin
    if (!rstN) begin
      s1Valid = 1'b0; s2Valid = 1'b0; heldExp = '0;
    end else begin
      s2Valid = s1Valid;
      if (s1Valid) begin heldExp = s1Exp; heldTag = s1Tag; end
      s1Valid = inValid;
      if (inValid) begin
        s1Exp = {1'b0, opA} + {1'b0, opB} + {{TW{1'b0}}, carryIn};
        s1Tag = curTag;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (outValid !== s2Valid) begin
        errors++;
        $display("FAIL R2 outValid actual=%0b expected=%0b", outValid, s2Valid);
      end
      checks++;
      if ({carryOut, sum} !== heldExp) begin
        errors++;
        $display("FAIL %s result actual=%h expected=%h",
                 s2Valid ? heldTag : "R7", {carryOut, sum}, heldExp);
      end
    end
  end

  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycleCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [TW-1:0] a, input logic [TW-1:0] b,
                      input logic cin, input string tag);
    @(negedge clk);
    opA = a; opB = b; carryIn = cin; inValid = 1'b1; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic logic [TW-1:0] rnd();
    logic [TW-1:0] v;
    for (int k = 0; k < TW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || sum !== '0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%0b/%h/%0b expected=0/0/0", outValid, sum, carryOut);
    end
    rstN = 1'b1;

    // R5: carry-in travels through every all-ones field
    send({TW{1'b1}}, '0, 1'b1, "R5");
    // R6: field 0 generates, field 1 bubbles, field 2 stops the chain
    send({64'h0, 64'h5, {64{1'b1}}, {64{1'b1}}},
         {64'h7, 64'h0, 64'h0, 64'h1}, 1'b0, "R6");
    // R8: top field generates a carry on its own
    send({64'h8000_0000_0000_0000, 192'h0},
         {64'h8000_0000_0000_0001, 192'h0}, 1'b0, "R8");
    // R8: top field wraps with a zero result bit, one operand top bit set
    send({64'hC000_0000_0000_0000, 192'h3},
         {64'h4000_0000_0000_0000, 192'h4}, 1'b1, "R8");
    idle(3);

    // R2/R3: random operands, back-to-back with idle gaps
    for (int n = 0; n < 300; n++) begin
      send(rnd(), rnd(), 1'($urandom), "R3");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);

    // R4: worked eight-field example
    @(negedge clk);
    smA = 64'h1931BA4C3D4521F1; smB = 64'h221245B3E2161736; smValid = 1'b1;
    @(negedge clk);
    smValid = 1'b0;
    @(negedge clk);
    checks++;
    if (smOutValid !== 1'b1 || smSum !== 64'h3B4400001F5B3927 || smCout !== 1'b0) begin
      errors++;
      $display("FAIL R4 actual=%0b/%h/%0b expected=1/3b4400001f5b3927/0",
               smOutValid, smSum, smCout);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule